// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

The scanner reads a matrix of up to six drive lines by five sense lines, 30 keys in all. While no key is down the drive lines sit at an idle pattern. A press pulls a sense line high and starts a scan. Each scan sweeps the drive lines twice, one line at a time, and captures a key snapshot on each sweep. A fixed number of time-base ticks after the scan starts, the two snapshots are compared. If they agree and a key is down, the result is latched on the key vector and an active-low read request is raised. If they differ while a key is still down, the scan restarts.

The host reads the key vector and then pulses a read-done strobe. This drops the request and starts a new scan. Scanning keeps repeating in this way until a scan finds every key released.

A sleep selector picks which drive lines stay high while idle, so that only keys on those lines can wake the scanner. A mode selector hands the two lowest drive lines over to other uses: those rows are then never driven and always read as zero. A serial-busy input forces the request line high while a transfer is running.

Top module: `kscan_top`

## Requirements
- R1: A sweep drives the enabled rows one at a time, lowest row first, each for `SLOT_TICKS` ticks (64 by default, so 384 ticks per sweep). During the sweep no more than one drive line is high, and the sense inputs are sampled on the last tick of each slot. Each scan makes two sweeps.
- R2: When both sweep snapshots agree and at least one key is down, the request falls after exactly `REQ_TICKS` ticks (800 by default), counted from the clock edge at which the scan started. The start edge itself is not counted.
- R3: If the two snapshots differ and the second one still shows a key, the scanner starts a new scan at once. The request then comes one full `REQ_TICKS` interval later and shows the stable key set.
- R4: A read-done pulse while the request is pending clears the request on the next edge and starts a new scan. If the keys are still held, this scan raises the request again after `REQ_TICKS` ticks with the same key vector.
- R5: While `ce_busy` is 1, `req_n` reads 1. Once `ce_busy` returns to 0, a pending request shows again.
- R6: Key bit index = row*5 + sense. Bit 0 is drive line 0 with sense 0, and bit 29 is drive line 5 with sense 4.
- R7: `drv_mode` 00 enables all rows. 01 disables row 0. 10 and 11 disable rows 0 and 1. A disabled row is never driven high, and its key bits always read 0, but it keeps its time slot in the sweep.
- R8: While idle, the enabled rows follow `sleep_sel`. With 00 or 11 all rows are high. With 01 only row 5 is high. With 10 rows 4 and 5 are high. All other rows are low.
- R9: A key on a row that is low while idle does not wake the scanner: the drive pattern and the request stay unchanged.
- R10: A scan that finds no key down returns the block to idle with a zero key vector and no request.
- R11: While reset is asserted, and on the first cycle after it is released, the drive output is 6'b100000. During reset `req_n` is 1 and the key vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base tick, one per T |
| sense | input | 5 | Matrix sense lines, high when a pressed key meets a high drive line |
| sleep_sel | input | 2 | Idle drive pattern select |
| drv_mode | input | 2 | Row enable mode |
| ce_busy | input | 1 | Serial transfer in progress |
| read_done | input | 1 | One-cycle strobe: the host has read the key vector |
| drive | output | 6 | Matrix drive lines |
| keys | output | 30 | Confirmed key vector |
| req_n | output | 1 | Active-low read request |

## Verification
The bench builds the block with its default parameters: six rows, five sense lines, 64-tick slots and an 800-tick request time. At these values the real 384-tick sweep and 800-tick request timing can be measured exactly. A scan still takes only about a thousand clock cycles, because the tick is pseudo-random and present on roughly three cycles in four, so many full press, read and release rounds fit in one run. A key matrix model in the bench drives the sense lines from the drive outputs. This makes the sleep wake-up rows, the skipped rows and the mid-scan press that causes a rescan all follow from real drive behaviour.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

  // Scanner control states
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_SCAN = 2'd1,
    KS_WAIT = 2'd2
  } kscan_state_e;

endpackage

// File: rtl/kscan_timebase.sv
// Slot, row, sweep and total-tick counters for one scan.
module kscan_timebase #(
  parameter int DRV_LINES  = 6,
  parameter int SLOT_TICKS = 64,
  parameter int REQ_TICKS  = 800,
  localparam int ROW_W = (DRV_LINES > 1) ? $clog2(DRV_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  output logic [ROW_W-1:0] row_idx,
  output logic             pass_idx,
  output logic             sweeping,
  output logic             slot_end,
  output logic             deadline
);

  localparam int SUB_W = $clog2(SLOT_TICKS + 1);
  localparam int TOT_W = $clog2(REQ_TICKS + 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [TOT_W-1:0] tot_q, tot_d;
  logic             pass_q, pass_d;
  logic             swept_q, swept_d;
  logic             adv;
  logic             upd_en;

  assign adv      = run && tick;
  assign upd_en   = restart || adv;
  assign slot_end = adv && !swept_q && (sub_q == SUB_W'(SLOT_TICKS - 1));
  assign deadline = adv && (tot_q == TOT_W'(REQ_TICKS - 1));
  assign row_idx  = row_q;
  assign pass_idx = pass_q;
  assign sweeping = !swept_q;

  always_comb begin
    sub_d   = sub_q;
    row_d   = row_q;
    tot_d   = tot_q;
    pass_d  = pass_q;
    swept_d = swept_q;
    if (restart) begin
      sub_d   = '0;
      row_d   = '0;
      tot_d   = '0;
      pass_d  = 1'b0;
      swept_d = 1'b0;
    end else if (adv) begin
      tot_d = tot_q + 1'b1;
      if (!swept_q) begin
        if (slot_end) begin
          sub_d = '0;
          if (row_q == ROW_W'(DRV_LINES - 1)) begin
            row_d = '0;
            if (pass_q) swept_d = 1'b1;
            else        pass_d  = 1'b1;
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      row_q   <= '0;
      tot_q   <= '0;
      pass_q  <= 1'b0;
      swept_q <= 1'b0;
    end else if (upd_en) begin
      sub_q   <= sub_d;
      row_q   <= row_d;
      tot_q   <= tot_d;
      pass_q  <= pass_d;
      swept_q <= swept_d;
    end
  end

  // R1: both sweeps are complete before the request time is reached
  assert_sweeps_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    deadline |-> swept_q);

endmodule

// File: rtl/kscan_snap.sv
// Two key snapshots, one per sweep, written row by row.
module kscan_snap #(
  parameter int DRV_LINES = 6,
  parameter int SNS_LINES = 5,
  localparam int ROW_W    = (DRV_LINES > 1) ? $clog2(DRV_LINES) : 1,
  localparam int KEY_BITS = DRV_LINES * SNS_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 slot_end,
  input  logic                 pass_idx,
  input  logic [ROW_W-1:0]     row_idx,
  input  logic [DRV_LINES-1:0] row_en,
  input  logic [SNS_LINES-1:0] sense,
  output logic [KEY_BITS-1:0]  snap_a,
  output logic [KEY_BITS-1:0]  snap_b
);

  for (genvar r = 0; r < DRV_LINES; r++) begin : g_row
    logic [SNS_LINES-1:0] a_q, a_d, b_q, b_d, field;
    logic                 hit;
    logic                 wr_en;

    assign hit   = slot_end && (row_idx == ROW_W'(r));
    assign field = sense & {SNS_LINES{row_en[r]}};
    assign wr_en = clear || hit;

    always_comb begin
      a_d = a_q;
      b_d = b_q;
      if (clear) begin
        a_d = '0;
        b_d = '0;
      end else if (hit) begin
        if (pass_idx) b_d = field;
        else          a_d = field;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
      end else if (wr_en) begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end

    assign snap_a[r*SNS_LINES +: SNS_LINES] = a_q;
    assign snap_b[r*SNS_LINES +: SNS_LINES] = b_q;
  end

endmodule

// File: rtl/kscan_fsm.sv
// Scan control: start, compare, request, read handshake.
module kscan_fsm
  import kscan_pkg::*;
#(
  parameter int KEY_BITS = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                any_sense,
  input  logic                deadline,
  input  logic [KEY_BITS-1:0] snap_a,
  input  logic [KEY_BITS-1:0] snap_b,
  input  logic                read_done,
  output kscan_state_e        state,
  output logic                restart,
  output logic [KEY_BITS-1:0] keys,
  output logic                req
);

  kscan_state_e        st_q, st_d;
  logic [KEY_BITS-1:0] keys_q, keys_d;
  logic                req_q, req_d;

  always_comb begin
    st_d    = st_q;
    keys_d  = keys_q;
    req_d   = req_q;
    restart = 1'b0;
    case (st_q)
      KS_IDLE: begin
        if (any_sense) begin
          st_d    = KS_SCAN;
          restart = 1'b1;
        end
      end
      KS_SCAN: begin
        if (deadline) begin
          if (snap_a == snap_b) begin
            keys_d = snap_b;
            if (|snap_b) begin
              req_d = 1'b1;
              st_d  = KS_WAIT;
            end else begin
              st_d = KS_IDLE;
            end
          end else if (|snap_b) begin
            restart = 1'b1;
          end else begin
            keys_d = '0;
            st_d   = KS_IDLE;
          end
        end
      end
      KS_WAIT: begin
        if (read_done) begin
          req_d   = 1'b0;
          st_d    = KS_SCAN;
          restart = 1'b1;
        end
      end
      default: st_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= KS_IDLE;
      keys_q <= '0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      keys_q <= keys_d;
      req_q  <= req_d;
    end
  end

  assign state = st_q;
  assign keys  = keys_q;
  assign req   = req_q;

  // R2: a request only follows a cycle in which both snapshots matched
  assert_match_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(snap_a == snap_b));

  // R4: read-done drops the request and begins a fresh scan
  assert_read_rescan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_WAIT && read_done) |=> (!req_q && st_q == KS_SCAN));

endmodule

// File: rtl/kscan_top.sv
module kscan_top
  import kscan_pkg::*;
#(
  parameter int DRV_LINES  = 6,
  parameter int SNS_LINES  = 5,
  parameter int SLOT_TICKS = 64,
  parameter int REQ_TICKS  = 800
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic [SNS_LINES-1:0]           sense,
  input  logic [1:0]                     sleep_sel,
  input  logic [1:0]                     drv_mode,
  input  logic                           ce_busy,
  input  logic                           read_done,
  output logic [DRV_LINES-1:0]           drive,
  output logic [DRV_LINES*SNS_LINES-1:0] keys,
  output logic                           req_n
);

  localparam int KEY_BITS = DRV_LINES * SNS_LINES;
  localparam int ROW_W    = (DRV_LINES > 1) ? $clog2(DRV_LINES) : 1;
  localparam logic [DRV_LINES-1:0] HOLD_PAT = {1'b1, {(DRV_LINES-1){1'b0}}};

  kscan_state_e         state;
  logic                 restart, sweeping, slot_end, deadline, pass_idx;
  logic [ROW_W-1:0]     row_idx;
  logic [KEY_BITS-1:0]  snap_a, snap_b, en_mask;
  logic [DRV_LINES-1:0] row_en, idle_pat, scan_pat;
  logic                 req;
  logic                 rst_hold_q;
  logic                 scan_run;

  // Row enables and idle/scan patterns
  for (genvar r = 0; r < DRV_LINES; r++) begin : g_pat
    if (r == 0) begin : g_r0
      assign row_en[r] = (drv_mode == 2'b00);
    end else if (r == 1) begin : g_r1
      assign row_en[r] = !drv_mode[1];
    end else begin : g_rn
      assign row_en[r] = 1'b1;
    end
    assign idle_pat[r] = (sleep_sel == 2'b01) ? (r == DRV_LINES - 1) :
                         (sleep_sel == 2'b10) ? (r >= DRV_LINES - 2) : 1'b1;
    assign scan_pat[r] = (row_idx == ROW_W'(r));
    assign en_mask[r*SNS_LINES +: SNS_LINES] = {SNS_LINES{row_en[r]}};
  end

  assign scan_run = (state == KS_SCAN);

  kscan_timebase #(
    .DRV_LINES (DRV_LINES),
    .SLOT_TICKS(SLOT_TICKS),
    .REQ_TICKS (REQ_TICKS)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (scan_run),
    .tick    (tick),
    .row_idx (row_idx),
    .pass_idx(pass_idx),
    .sweeping(sweeping),
    .slot_end(slot_end),
    .deadline(deadline)
  );

  kscan_snap #(
    .DRV_LINES(DRV_LINES),
    .SNS_LINES(SNS_LINES)
  ) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .slot_end(slot_end),
    .pass_idx(pass_idx),
    .row_idx (row_idx),
    .row_en  (row_en),
    .sense   (sense),
    .snap_a  (snap_a),
    .snap_b  (snap_b)
  );

  kscan_fsm #(
    .KEY_BITS(KEY_BITS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_sense(|sense),
    .deadline (deadline),
    .snap_a   (snap_a),
    .snap_b   (snap_b),
    .read_done(read_done),
    .state    (state),
    .restart  (restart),
    .keys     (keys),
    .req      (req)
  );

  // Holds the reset drive pattern until the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_hold_q <= 1'b1;
    else        rst_hold_q <= 1'b0;
  end

  always_comb begin
    if (rst_hold_q)                 drive = HOLD_PAT;
    else if (scan_run && sweeping)  drive = scan_pat & row_en;
    else                            drive = idle_pat & row_en;
  end

  assign req_n = !req || ce_busy;

  // R1: at most one drive line is high while sweeping
  assert_single_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_run && sweeping && !rst_hold_q) |-> $onehot0(drive));

  // R7: a fresh result carries no bits of disabled rows
  assert_masked_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ((keys & ~en_mask) == '0));

  // R10: no request is pending while idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_IDLE) |-> req_n);

endmodule

// File: tb/kscan_top_test.sv
module kscan_top_test;

  localparam int DRV  = 6;
  localparam int SNS  = 5;
  localparam int SLOT = 64;
  localparam int REQ  = 800;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick = 1'b0;
  logic [SNS-1:0] sense;
  logic [1:0]     sleep_sel, drv_mode;
  logic           ce_busy, read_done;
  logic [DRV-1:0] drive;
  logic [DRV*SNS-1:0] keys;
  logic           req_n;

  logic [DRV-1:0][SNS-1:0] pressed;
  int vectors = 0;
  int miscomp = 0;
  int tick_cnt = 0;

  always #10 clk = ~clk;

  kscan_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense(sense),
    .sleep_sel(sleep_sel), .drv_mode(drv_mode), .ce_busy(ce_busy),
    .read_done(read_done), .drive(drive), .keys(keys), .req_n(req_n)
  );

  // Ideal key matrix
  always_comb begin
    sense = '0;
    for (int r = 0; r < DRV; r++)
      if (drive[r]) sense = sense | pressed[r];
  end

  always @(negedge clk) tick <= (($urandom % 4) != 0);
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  function automatic logic row_on(int r, logic [1:0] m);
    if (r == 0) return (m == 2'b00);
    if (r == 1) return !m[1];
    return 1'b1;
  endfunction

  function automatic logic [DRV-1:0] idle_exp(logic [1:0] s, logic [1:0] m);
    logic [DRV-1:0] v;
    for (int r = 0; r < DRV; r++) begin
      logic hi;
      hi = (s == 2'b01) ? (r == 5) : (s == 2'b10) ? (r >= 4) : 1'b1;
      v[r] = hi & row_on(r, m);
    end
    return v;
  endfunction

  function automatic logic [DRV*SNS-1:0] keys_exp(logic [DRV-1:0][SNS-1:0] p, logic [1:0] m);
    logic [DRV*SNS-1:0] k;
    k = '0;
    for (int r = 0; r < DRV; r++)
      if (row_on(r, m)) k[r*SNS +: SNS] = p[r];
    return k;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_scan_start(output int t0);
    int n;
    n = 0;
    while (drive == idle_exp(sleep_sel, drv_mode) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    t0 = tick_cnt;
  endtask

  task automatic wait_req(input int t0, output int t);
    int n;
    n = 0;
    while (req_n !== 1'b0 && n < 8000) begin
      @(negedge clk);
      n++;
    end
    t = (req_n === 1'b0) ? (tick_cnt - t0) : -1;
  endtask

  task automatic wait_ticks(input int n);
    int t0;
    t0 = tick_cnt;
    while (tick_cnt - t0 < n) @(negedge clk);
  endtask

  task automatic pulse_read();
    @(negedge clk) read_done = 1'b1;
    @(negedge clk) read_done = 1'b0;
  endtask

  task automatic release_and_settle();
    pressed = '0;
    if (req_n === 1'b0) pulse_read();
    wait_ticks(REQ + 40);
    chk("R10 keys after release", keys, 0);
    chk("R10 no request after release", req_n, 1);
    chk("R10 idle drive after release", drive, idle_exp(sleep_sel, drv_mode));
  endtask

  task automatic run_trial(input int n);
    logic [1:0] s, m;
    logic [DRV-1:0] hi;
    logic [DRV-1:0][SNS-1:0] p;
    int r, t0, t1, t;
    s = 2'($urandom % 4);
    m = 2'($urandom % 4);
    sleep_sel = s;
    drv_mode  = m;
    repeat (3) @(negedge clk);
    chk("R8 idle drive pattern", drive, idle_exp(s, m));
    hi = idle_exp(s, m);
    p = '0;
    r = $urandom % DRV;
    while (!hi[r]) r = $urandom % DRV;
    p[r][$urandom % SNS] = 1'b1;
    if ($urandom % 2) p[$urandom % DRV][$urandom % SNS] = 1'b1;
    pressed = p;
    wait_scan_start(t0);
    if (m == 2'b00) begin
      chk("R1 first row driven", drive, 6'b000001);
      while (drive == 6'b000001) @(negedge clk);
      t1 = tick_cnt - t0;
      chk("R1 slot length", t1, SLOT);
      chk("R1 next row driven", drive, 6'b000010);
    end
    wait_req(t0, t);
    chk("R2 request time", t, REQ);
    chk("R6 R7 key vector", keys, keys_exp(p, m));
    if (n % 2) begin
      ce_busy = 1'b1;
      @(negedge clk);
      chk("R5 request masked by busy", req_n, 1);
      ce_busy = 1'b0;
      @(negedge clk);
      chk("R5 request back after busy", req_n, 0);
    end
    pulse_read();
    chk("R4 request cleared by read", req_n, 1);
    t0 = tick_cnt;
    wait_req(t0, t);
    chk("R4 rescan request time", t, REQ);
    chk("R4 same keys after rescan", keys, keys_exp(p, m));
    release_and_settle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscomp++;
    $display("FAIL R2 watchdog: got %0d cycles expected fewer", 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    int t0, t;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    pressed = '0;
    sleep_sel = 2'b00;
    drv_mode = 2'b00;
    ce_busy = 1'b0;
    read_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 drive in reset", drive, 6'b100000);
    chk("R11 request in reset", req_n, 1);
    chk("R11 keys in reset", keys, 0);
    rst_n = 1'b1;
    chk("R11 drive first cycle after release", drive, 6'b100000);
    repeat (3) @(negedge clk);
    chk("R8 normal idle all high", drive, 6'b111111);

    // R9: key on a low row in sleep does not wake
    sleep_sel = 2'b01;
    repeat (2) @(negedge clk);
    pressed[0][1] = 1'b1;
    repeat (1500) @(negedge clk);
    chk("R9 drive unchanged", drive, 6'b100000);
    chk("R9 no request", req_n, 1);
    chk("R9 keys untouched", keys, 0);
    pressed = '0;

    // R3: key added during the second sweep forces a rescan
    sleep_sel = 2'b00;
    repeat (2) @(negedge clk);
    pressed[0][0] = 1'b1;
    wait_scan_start(t0);
    while (tick_cnt - t0 < 500) @(negedge clk);
    pressed[5][2] = 1'b1;
    wait_req(t0, t);
    chk("R3 request after rescan", t, 2 * REQ);
    chk("R3 R6 stable key set", keys, 30'h0800_0001);
    release_and_settle();

    for (int i = 0; i < 12; i++) run_trial(i);

    // R11: reset while a request is pending
    sleep_sel = 2'b00;
    drv_mode = 2'b00;
    repeat (2) @(negedge clk);
    pressed[3][4] = 1'b1;
    wait_scan_start(t0);
    wait_req(t0, t);
    chk("R6 row 3 sense 4 bit", keys, 30'h0008_0000);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 keys cleared by reset", keys, 0);
    chk("R11 request high in reset", req_n, 1);
    chk("R11 drive in late reset", drive, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    release_and_settle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule